// File: doc/BRIEF.md
# Multi-Word Remainder by a Single Word

This block finds the remainder of a long unsigned integer divided by one word. The integer is stored as a sequence of `WORD_W`-bit words, with the least significant word at index 0. A command supplies three values: the word count, the divisor and a start pulse. The block then walks the operand from the top index down to index 0, fetching one word per step through a synchronous read port. The read port returns data one cycle after the request.

At each step the block forms a double-width dividend. Its upper half is the remainder so far and its lower half is the word just fetched. It divides this value by the divisor with an internal restoring divider that runs one shift-and-subtract iteration per cycle. The step keeps only the remainder and discards the quotient. The remainder so far is always below the divisor, so the quotient of a step always fits in one word and no overflow case arises.

When the word at index 0 has been consumed, the block presents the final remainder and raises a one-cycle completion strobe. A zero divisor does not start a walk: the block completes at once, raises an error flag and issues no reads.

Top module: `wordwise_modulo`

## Requirements
- R1: While reset is held, and after it is released, `done_o`, `busy_o`, `rd_en_o` and `div_err_o` are 0 and `rem_o` is 0.
- R2: After a command with word count L > 0 and a nonzero divisor D, `rem_o` equals (sum over i of word[i]·2^(WORD_W·i)) mod D, where word[i] is the data returned for address i.
- R3: A command issues exactly L reads, at addresses L−1, L−2, …, 0 in that order, each as a single-cycle `rd_en_o`. The bench drives `rd_data_i` in the cycle after each read.
- R4: The remainder so far starts at zero for every command and stays strictly below the divisor at every iteration.
- R5: Each word costs one fetch cycle plus WORD_W divide iterations, so `done_o` rises in the cycle that follows the (WORD_W+1)·L-th clock edge after the edge that accepts the start.
- R6: A zero divisor completes in the cycle after the accepting edge. It sets `div_err_o` to 1, sets `rem_o` to 0 and makes no read.
- R7: A word count of zero with a nonzero divisor completes in the cycle after the accepting edge. It sets `rem_o` to 0 and `div_err_o` to 0 and makes no read.
- R8: `done_o` lasts exactly one cycle. `rem_o` and `div_err_o` keep their values until the next completion, and a good completion clears `div_err_o`.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored: it changes neither the result nor the read sequence, and produces no extra completion.
- R10: `busy_o` is 1 from the accepting edge until the completion edge of a command that walks the operand, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| len_i | input | LEN_W | Number of operand words |
| divisor_i | input | WORD_W | Divisor |
| rd_en_o | output | 1 | Word read request |
| rd_addr_o | output | LEN_W | Word index to read |
| rd_data_i | input | WORD_W | Read data, valid one cycle after the request |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion strobe |
| rem_o | output | WORD_W | Final remainder |
| div_err_o | output | 1 | Last command had a zero divisor |

## Verification
The bench runs the walk with the following patterns, each aimed at a different failure:

- A single word, which isolates one divide step.
- Several mixed words over a maximal divisor.
- A divisor of one, which must give a zero remainder.
- All-ones words over a divisor just below the maximum, which keeps the remainder near the divisor and stresses the subtract path.
- A forty-word generated operand over a divisor with a high bit set, which catches word order and chaining errors.

Zero divisors and zero lengths check the immediate-completion paths. A start that arrives mid-walk, and an error followed by a good command, separate a correct command latch from a latch that can be overwritten.

// File: rtl/wmod_pkg.sv
package wmod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ITER  = 2'd2
  } wmod_state_e;
endpackage

// File: rtl/wmod_step.sv
module wmod_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] part_rem,
  input  logic         in_bit,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] next_rem
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted  = {part_rem, in_bit};
    diff     = shifted - {1'b0, divisor};
    fits     = shifted >= {1'b0, divisor};
    next_rem = fits ? diff[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/wmod_datapath.sv
module wmod_datapath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] div_in,
  input  logic         step_en,
  input  logic         step_first,
  input  logic         fin_last,
  input  logic         fin_zero,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] result
);
  logic [W-1:0] div_q, div_d;
  logic [W-1:0] part_q, part_d;
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] res_q, res_d;
  logic [W-1:0] step_rem;
  logic         in_bit;

  assign in_bit = step_first ? word_in[W-1] : sh_q[W-1];

  wmod_step #(.W(W)) u_step (
    .part_rem (part_q),
    .in_bit   (in_bit),
    .divisor  (div_q),
    .next_rem (step_rem)
  );

  always_comb begin
    div_d  = div_q;
    part_d = part_q;
    sh_d   = sh_q;
    res_d  = res_q;
    if (load) begin
      div_d  = div_in;
      part_d = '0;
    end
    if (step_en) begin
      part_d = step_rem;
      sh_d   = step_first ? {word_in[W-2:0], 1'b0} : {sh_q[W-2:0], 1'b0};
    end
    if (fin_zero) res_d = '0;
    if (fin_last) res_d = step_rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      part_q <= '0;
      sh_q   <= '0;
      res_q  <= '0;
    end else begin
      if (load) div_q <= div_d;
      if (load || step_en) begin
        part_q <= part_d;
        sh_q   <= sh_d;
      end
      if (fin_zero || fin_last) res_q <= res_d;
    end
  end

  assign result = res_q;

  // R4
  part_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> part_q < div_q);

  // R4
  step_result_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> part_q < div_q);

  // R4
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> part_q == '0);
endmodule

// File: rtl/wmod_ctrl.sv
module wmod_ctrl
  import wmod_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             div_zero,
  output logic             accept,
  output logic             step_en,
  output logic             step_first,
  output logic             fin_last,
  output logic             fin_zero,
  output logic             rd_en_o,
  output logic [LEN_W-1:0] rd_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int ITER_W = $clog2(W);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(W - 1);

  wmod_state_e      state_q, state_d;
  logic [LEN_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             last_iter;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign fin_zero   = accept && (div_zero || (len_i == '0));
  assign step_en    = (state_q == ST_ITER);
  assign last_iter  = (iter_q == LAST_ITER);
  assign step_first = step_en && (iter_q == '0);
  assign fin_last   = step_en && last_iter && (addr_q == '0);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    len_d   = len_q;
    iter_d  = iter_q;
    done_d  = 1'b0;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          len_d = len_i;
          if (fin_zero) begin
            done_d = 1'b1;
            err_d  = div_zero;
          end else begin
            addr_d  = len_i - LEN_W'(1);
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        iter_d  = '0;
        state_d = ST_ITER;
      end
      ST_ITER: begin
        iter_d = iter_q + ITER_W'(1);
        if (last_iter) begin
          if (addr_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b0;
          end else begin
            addr_d  = addr_q - LEN_W'(1);
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept || step_en) addr_q <= addr_d;
      if (accept) len_q <= len_d;
      if (step_en || state_q == ST_FETCH) iter_q <= iter_d;
      if (done_d) err_q <= err_d;
    end
  end

  assign rd_en_o   = (state_q == ST_FETCH);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

  // R3
  fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> rd_addr_o < len_q);

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && div_zero) |=> (done_o && err_o && !busy_o));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !div_zero && len_i != '0) |=> busy_o && !done_o);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(len_q));
endmodule

// File: rtl/wordwise_modulo.sv
module wordwise_modulo #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] divisor_i,
  output logic              rd_en_o,
  output logic [LEN_W-1:0]  rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rem_o,
  output logic              div_err_o
);
  logic div_zero;
  logic accept, step_en, step_first, fin_last, fin_zero;

  assign div_zero = (divisor_i == '0);

  wmod_ctrl #(.W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_i      (len_i),
    .div_zero   (div_zero),
    .accept     (accept),
    .step_en    (step_en),
    .step_first (step_first),
    .fin_last   (fin_last),
    .fin_zero   (fin_zero),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (div_err_o)
  );

  wmod_datapath #(.W(WORD_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .div_in     (divisor_i),
    .step_en    (step_en),
    .step_first (step_first),
    .fin_last   (fin_last),
    .fin_zero   (fin_zero),
    .word_in    (rd_data_i),
    .result     (rem_o)
  );

  // R6
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_en_o);
endmodule

// File: tb/wordwise_modulo_test.sv
module wordwise_modulo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  len_i = '0;
  logic [15:0] divisor_i = '0;
  logic        rd_en_o;
  logic [7:0]  rd_addr_o;
  logic [15:0] rd_data_i;
  logic        busy_o, done_o, div_err_o;
  logic [15:0] rem_o;

  always #10 clk = ~clk;

  wordwise_modulo #(.WORD_W(16), .LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .divisor_i(divisor_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .rem_o(rem_o), .div_err_o(div_err_o)
  );

  logic [15:0] mem [0:63];
  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o[5:0]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [15:0] rem;
    logic        err;
    int          lat;
    int          sc;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   addrq[$];
  int   tests = 0;
  int   fails = 0;
  bit   ended = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Monitor: completions and reads, compared against the scoreboard queues
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (prev_done && done_o) check(1'b0, "R8", "done longer than one cycle", 1, 0);
      if (done_o) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected completion", 1, 0);
        end else begin
          e = expq.pop_front();
          check(rem_o == e.rem, "R2", {e.tag, " remainder"}, rem_o, e.rem);
          check(div_err_o == e.err, "R6", {e.tag, " error flag"}, div_err_o, e.err);
          check((cyc - e.sc) == e.lat, "R5", {e.tag, " latency"}, cyc - e.sc, e.lat);
        end
      end
      if (rd_en_o) begin
        if (addrq.size() == 0) check(1'b0, "R3", "unexpected read", rd_addr_o, 0);
        else begin
          int a;
          a = addrq.pop_front();
          check(int'(rd_addr_o) == a, "R3", "read address order", rd_addr_o, a);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic fill(input int n, input int seed, input int kind);
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: mem[i] = 16'(i * 40503 + seed);
        1: mem[i] = 16'hFFFF;
        default: mem[i] = 16'(seed + i * 7);
      endcase
    end
  endtask

  task automatic run_cmd(input int n, input logic [15:0] dv, input string tg);
    exp_t e;
    logic [15:0] r;
    r = '0;
    if (dv != 0) for (int i = n - 1; i >= 0; i--) r = 16'({r, mem[i]} % {16'd0, dv});
    e.rem = r;
    e.err = (dv == 0);
    e.lat = (dv == 0 || n == 0) ? 1 : 17 * n + 1;
    e.tag = tg;
    if (dv != 0) for (int i = n - 1; i >= 0; i--) addrq.push_back(i);
    @(negedge clk);
    start_i = 1'b1; len_i = 8'(n); divisor_i = dv;
    e.sc = cyc;
    expq.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    // R10: busy in the cycle after acceptance only for a walking command
    check(busy_o == (n > 0 && dv != 0), "R10", {tg, " busy after start"}, busy_o, (n > 0 && dv != 0));
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check({done_o, busy_o, rd_en_o, div_err_o} == 4'b0, "R1", "flags in reset", {done_o, busy_o, rd_en_o, div_err_o}, 0);
    check(rem_o == 16'h0, "R1", "remainder in reset", rem_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({done_o, busy_o, rd_en_o, div_err_o} == 4'b0, "R1", "flags after reset", {done_o, busy_o, rd_en_o, div_err_o}, 0);

    // R2 R4: single word
    mem[0] = 16'h1234;
    run_cmd(1, 16'd7, "one word");
    wait_idle();

    // R2: mixed words, maximal divisor
    mem[0] = 16'hBEEF; mem[1] = 16'h0001; mem[2] = 16'hFFFF; mem[3] = 16'h8000;
    run_cmd(4, 16'hFFFF, "four words");
    wait_idle();

    // R2: divisor one gives zero
    run_cmd(4, 16'd1, "divisor one");
    wait_idle();

    // R4: remainder kept near divisor
    fill(6, 0, 1);
    run_cmd(6, 16'hFFFE, "all ones");
    wait_idle();

    // R8: result held after completion
    held = rem_o;
    repeat (5) @(negedge clk);
    check(rem_o == held, "R8", "remainder held", rem_o, held);

    // R6: zero divisor
    run_cmd(5, 16'd0, "zero divisor");
    wait_idle();
    repeat (3) @(negedge clk);
    check(div_err_o == 1'b1, "R8", "error flag held", div_err_o, 1);

    // R7: zero length, also clears the error
    run_cmd(0, 16'd9, "zero length");
    wait_idle();
    check(rem_o == 16'h0, "R7", "zero length remainder", rem_o, 0);

    // R2 R3: long generated operand
    fill(40, 12345, 0);
    run_cmd(40, 16'h8001, "forty words");
    wait_idle();

    // R9: start during a walk is ignored
    fill(3, 777, 2);
    run_cmd(3, 16'd1000, "busy start");
    repeat (20) @(negedge clk);
    start_i = 1'b1; len_i = 8'd2; divisor_i = 16'd5;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    check(!busy_o && addrq.size() == 0, "R9", "no extra walk", busy_o, 0);

    // R8: error then good command clears the flag
    run_cmd(2, 16'd0, "err again");
    wait_idle();
    run_cmd(2, 16'd3, "clear err");
    wait_idle();
    check(div_err_o == 1'b0, "R8", "error cleared", div_err_o, 0);

    summary();
  end
endmodule